// File: doc/BRIEF.md
# Latency-Scheduled Writeback Execution Core

This block is the execution engine of a microcoded vertex coprocessor. It runs a program of 32-bit instruction words held in an on-chip store. For each instruction it reads two operands from a 128-entry, 32-bit register file and computes a result. It computes copy, absolute value, conditional select, sign transfer and the reciprocal-square-root seed itself. It hands every other arithmetic opcode to an external function unit, which answers in the same cycle on `fu_result`.

A result is not written back when it is produced. It is parked in a 7-slot circular writeback queue, at a position set by the fixed latency of its opcode. On every step the slot at the queue head is committed into the register named by the destination field of the *current* instruction. The program therefore places its writebacks explicitly. The emit opcode presents two registers on the vector output, stops the program and returns the core to idle. A host loads the instruction store and the registers while the core is idle, pulses `start`, and reads the results back through the register read port.

Top module: `vxc_exec_core`

## Requirements
- R1: After reset, `busy` and `vec_valid` are 0.
- R2: The instruction word is decoded as operand A register in bits 24:18, operand B register in bits 17:11, opcode in bits 10:7 and destination register in bits 6:0.
- R3: The opcodes are 0 no-op, 1 add, 2 subtract, 3 multiply, 4 absolute, 5 float-to-int, 6 int-to-float, 7 emit, 8 sine, 9 cosine, 10 greater, 11 equal, 12 copy, 13 select, 14 sign transfer and 15 rsqrt seed. A result issued at step k with latency L is committed by the destination field of the instruction at step k+L. On every non-emit step the head slot is read and then cleared, so a slot with no pending result commits 0.
- R4: The latencies are multiply 7, add 5, subtract 5, sine 4, cosine 4, int-to-float 3, and 2 for every other opcode that produces a result. No-op and emit insert nothing.
- R5: A destination field of 0 writes no register.
- R6: When two results land in the same queue slot, the one issued later is kept.
- R7: Emit drives `vec_a` and `vec_b` with registers A and B and pulses `vec_valid` for one cycle as `busy` falls. It writes no register and does not advance the queue.
- R8: Select returns operand A when register 2 is nonzero and operand B otherwise.
- R9: Absolute value clears bit 31 of A. Sign transfer returns A with bit 31 inverted when bit 31 of B is set, and returns A unchanged otherwise.
- R10: The rsqrt seed returns 0x5F3759DF minus (A >> 1).
- R11: Copy returns A. The opcodes add, subtract, multiply, both conversions, sine, cosine, greater and equal present the opcode and both operands on `fu_op`, `fu_a` and `fu_b`, and take their result from `fu_result`.
- R12: `start` sets the program counter to 0, empties every queue slot and makes `busy` 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Restart the program from address 0 with an empty queue |
| busy | output | 1 | Program running |
| uc_we | input | 1 | Instruction store write enable |
| uc_waddr | input | 9 | Instruction store write address |
| uc_wdata | input | 32 | Instruction word to store |
| rf_we | input | 1 | Host register write (taken only when idle) |
| rf_waddr | input | 7 | Host register write index |
| rf_wdata | input | 32 | Host register write data |
| rf_raddr | input | 7 | Host register read index |
| rf_rdata | output | 32 | Registered host read data, one cycle after the address |
| fu_op | output | 4 | Opcode presented to the external function unit |
| fu_a | output | 32 | Operand A to the function unit |
| fu_b | output | 32 | Operand B to the function unit |
| fu_result | input | 32 | Same-cycle result from the function unit |
| vec_valid | output | 1 | One-cycle pulse when emit runs |
| vec_a | output | 32 | Register A value at emit |
| vec_b | output | 32 | Register B value at emit |

## Verification
A wrong head pointer or a wrong insertion index does not show up at the step that caused it. It surfaces one to seven steps later, when a destination field commits a zero, or another result, into a register the program then emits or the host reads back. Each program therefore pairs every issue with a commit at exactly step k+L and also places a destination one step earlier, so a latency that is off by one changes a visible register. The tests also target a queue that is not cleared on restart and an emit that wrongly advances the queue. Each of these is set up so that it changes `vec_a` on the following program, within a few cycles.

// File: rtl/vxc_pkg.sv
package vxc_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,  OP_ADD  = 4'd1,  OP_SUB  = 4'd2,  OP_MUL  = 4'd3,
    OP_ABS  = 4'd4,  OP_FTOI = 4'd5,  OP_ITOF = 4'd6,  OP_EMIT = 4'd7,
    OP_SIN  = 4'd8,  OP_COS  = 4'd9,  OP_GT   = 4'd10, OP_EQ   = 4'd11,
    OP_MOV  = 4'd12, OP_SEL  = 4'd13, OP_SGNX = 4'd14, OP_RSQS = 4'd15
  } opcode_e;

  // operand A 24:18, operand B 17:11, opcode 10:7, destination 6:0
  typedef struct packed {
    logic [6:0] spare;
    logic [6:0] ra;
    logic [6:0] rb;
    opcode_e    op;
    logic [6:0] rd;
  } insn_t;

  localparam logic [31:0] RSQ_MAGIC = 32'h5F37_59DF;
  localparam int unsigned MAX_LAT   = 7;

  function automatic logic [3:0] op_latency(opcode_e op);
    case (op)
      OP_MUL:                         return 4'd7;
      OP_ADD, OP_SUB:                 return 4'd5;
      OP_SIN, OP_COS:                 return 4'd4;
      OP_ITOF:                        return 4'd3;
      OP_NOP, OP_EMIT:                return 4'd0;
      default:                        return 4'd2;
    endcase
  endfunction

  function automatic logic uses_fu(opcode_e op);
    case (op)
      OP_ADD, OP_SUB, OP_MUL, OP_FTOI, OP_ITOF,
      OP_SIN, OP_COS, OP_GT, OP_EQ:   return 1'b1;
      default:                        return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/vxc_ucode_mem.sv
module vxc_ucode_mem #(
  parameter int DEPTH = 512,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // single write port, registered read: maps to a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/vxc_regfile.sv
module vxc_regfile #(
  parameter int DEPTH = 128,
  parameter int DW    = 32,
  parameter int FLAG_REG = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] a_addr,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] a_data,
  output logic [DW-1:0] b_data,
  output logic          flag_nz,
  input  logic [AW-1:0] h_addr,
  output logic [DW-1:0] h_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    h_data <= mem[h_addr];
  end

  // operand reads see the value before this step's commit
  assign a_data  = mem[a_addr];
  assign b_data  = mem[b_addr];
  assign flag_nz = |mem[FLAG_REG];
endmodule

// File: rtl/vxc_bitops.sv
module vxc_bitops
  import vxc_pkg::*;
#(
  parameter int DW = 32
) (
  input  opcode_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          flag_nz,
  input  logic [DW-1:0] fu_result,
  output logic [DW-1:0] res
);
  always_comb begin
    case (op)
      OP_MOV:  res = a;
      OP_ABS:  res = {1'b0, a[DW-2:0]};
      OP_SEL:  res = flag_nz ? a : b;
      OP_SGNX: res = {a[DW-1] ^ b[DW-1], a[DW-2:0]};
      OP_RSQS: res = RSQ_MAGIC - (a >> 1);
      OP_NOP, OP_EMIT: res = '0;
      default: res = fu_result;
    endcase
  end
endmodule

// File: rtl/vxc_wb_queue.sv
module vxc_wb_queue #(
  parameter int DEPTH = 7,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          advance,
  input  logic          ins_en,
  input  logic [LW-1:0] ins_lat,
  input  logic [DW-1:0] ins_data,
  output logic [DW-1:0] head_data
);
  logic [DW-1:0] slot [DEPTH];
  logic [PW-1:0] head, head_nxt, ins_idx;
  logic [PW:0]   sum;

  assign head_nxt = (head == PW'(DEPTH - 1)) ? '0 : head + 1'b1;
  // (head+1) + lat - 1 modulo DEPTH
  assign sum      = (PW+1)'(head) + (PW+1)'(ins_lat);
  assign ins_idx  = (sum >= (PW+1)'(DEPTH)) ? PW'(sum - (PW+1)'(DEPTH)) : PW'(sum);
  assign head_data = slot[head];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      head <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (advance) begin
      slot[head] <= '0;
      head       <= head_nxt;
      // later statement wins: a new insert overrides the clear or an older entry
      if (ins_en) slot[ins_idx] <= ins_data;
    end
  end

  // R3
  head_range_chk: assert property (@(posedge clk) disable iff (rst)
    head < PW'(DEPTH));

  // R12
  clr_head_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (head == '0 && head_data == '0));
endmodule

// File: rtl/vxc_exec_core.sv
module vxc_exec_core
  import vxc_pkg::*;
#(
  parameter int UC_DEPTH = 512,
  parameter int RF_DEPTH = 128,
  parameter int Q_DEPTH  = 7,
  parameter int DW       = 32,
  localparam int UCAW    = $clog2(UC_DEPTH),
  localparam int RAW     = $clog2(RF_DEPTH),
  localparam int LW      = $clog2(Q_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output logic            busy,
  input  logic            uc_we,
  input  logic [UCAW-1:0] uc_waddr,
  input  logic [DW-1:0]   uc_wdata,
  input  logic            rf_we,
  input  logic [RAW-1:0]  rf_waddr,
  input  logic [DW-1:0]   rf_wdata,
  input  logic [RAW-1:0]  rf_raddr,
  output logic [DW-1:0]   rf_rdata,
  output logic [3:0]      fu_op,
  output logic [DW-1:0]   fu_a,
  output logic [DW-1:0]   fu_b,
  input  logic [DW-1:0]   fu_result,
  output logic            vec_valid,
  output logic [DW-1:0]   vec_a,
  output logic [DW-1:0]   vec_b
);
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC} state_e;

  state_e          st;
  logic [UCAW-1:0] pc;
  logic [DW-1:0]   iword;
  insn_t           ins;
  logic [DW-1:0]   a_data, b_data, res, head_data;
  logic            flag_nz, step, is_emit;
  logic            wr_en, core_we, host_we;
  logic [RAW-1:0]  wr_addr;
  logic [DW-1:0]   wr_data;

  vxc_ucode_mem #(.DEPTH(UC_DEPTH), .DW(DW)) u_ucode (
    .clk(clk), .we(uc_we), .waddr(uc_waddr), .wdata(uc_wdata),
    .raddr(pc), .rdata(iword)
  );

  assign ins     = insn_t'(iword);
  assign is_emit = (st == ST_EXEC) && (ins.op == OP_EMIT);
  assign step    = (st == ST_EXEC) && (ins.op != OP_EMIT) && !start;

  assign core_we = step && (ins.rd != '0);
  assign host_we = rf_we && (st == ST_IDLE);
  assign wr_en   = core_we || host_we;
  assign wr_addr = core_we ? RAW'(ins.rd) : rf_waddr;
  assign wr_data = core_we ? head_data : rf_wdata;

  vxc_regfile #(.DEPTH(RF_DEPTH), .DW(DW)) u_rf (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .a_addr(RAW'(ins.ra)), .b_addr(RAW'(ins.rb)),
    .a_data(a_data), .b_data(b_data), .flag_nz(flag_nz),
    .h_addr(rf_raddr), .h_data(rf_rdata)
  );

  vxc_bitops #(.DW(DW)) u_ops (
    .op(ins.op), .a(a_data), .b(b_data), .flag_nz(flag_nz),
    .fu_result(fu_result), .res(res)
  );

  vxc_wb_queue #(.DEPTH(Q_DEPTH), .DW(DW)) u_q (
    .clk(clk), .rst(rst), .clr(start), .advance(step),
    .ins_en(ins.op != OP_NOP), .ins_lat(LW'(op_latency(ins.op))),
    .ins_data(res), .head_data(head_data)
  );

  assign fu_op = uses_fu(ins.op) ? ins.op : OP_NOP;
  assign fu_a  = a_data;
  assign fu_b  = b_data;
  assign busy  = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      pc        <= '0;
      vec_valid <= 1'b0;
      vec_a     <= '0;
      vec_b     <= '0;
    end else begin
      vec_valid <= 1'b0;
      if (start) begin
        pc <= '0;
        st <= ST_FETCH;
      end else begin
        case (st)
          ST_FETCH: st <= ST_EXEC;
          ST_EXEC: begin
            if (is_emit) begin
              vec_valid <= 1'b1;
              vec_a     <= a_data;
              vec_b     <= b_data;
              st        <= ST_IDLE;
            end else begin
              pc <= pc + 1'b1;
              st <= ST_FETCH;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R7
  vec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> !vec_valid);

  // R7
  vec_idle_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> !busy);

  // R12
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  // R7
  emit_stops_chk: assert property (@(posedge clk) disable iff (rst)
    (is_emit && !start) |=> (!busy && vec_valid));
endmodule

// File: tb/vxc_exec_core_tb.sv
module vxc_exec_core_tb;
  localparam int OPN = 0, OADD = 1, OSUB = 2, OMUL = 3, OABS = 4, OFTOI = 5,
                 OITOF = 6, OEMIT = 7, OSIN = 8, OCOS = 9, OMOV = 12,
                 OSEL = 13, OSGNX = 14, ORSQS = 15;

  logic clk = 0, rst = 1, start = 0;
  logic busy, uc_we = 0, rf_we = 0, vec_valid;
  logic [8:0]  uc_waddr = 0;
  logic [31:0] uc_wdata = 0, rf_wdata = 0, fu_a, fu_b, fu_result, rf_rdata, vec_a, vec_b;
  logic [6:0]  rf_waddr = 0, rf_raddr = 0;
  logic [3:0]  fu_op;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  // function-unit stand-in: a + 2b + opcode
  assign fu_result = fu_a + (fu_b << 1) + {28'd0, fu_op};

  vxc_exec_core u_dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .uc_we(uc_we), .uc_waddr(uc_waddr), .uc_wdata(uc_wdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .fu_op(fu_op), .fu_a(fu_a), .fu_b(fu_b), .fu_result(fu_result),
    .vec_valid(vec_valid), .vec_a(vec_a), .vec_b(vec_b)
  );

  function automatic logic [31:0] mk(int op, int ra, int rb, int rd);
    return {7'd0, 7'(ra), 7'(rb), 4'(op), 7'(rd)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic put(int idx, logic [31:0] w);
    @(negedge clk); uc_we = 1; uc_waddr = 9'(idx); uc_wdata = w;
    @(negedge clk); uc_we = 0;
  endtask

  task automatic setr(int idx, logic [31:0] v);
    @(negedge clk); rf_we = 1; rf_waddr = 7'(idx); rf_wdata = v;
    @(negedge clk); rf_we = 0;
  endtask

  task automatic getr(int idx, output logic [31:0] v);
    @(negedge clk); rf_raddr = 7'(idx);
    @(negedge clk); v = rf_rdata;
  endtask

  task automatic run(output logic [31:0] va, output logic [31:0] vb);
    int n = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!vec_valid && n < 2000) begin @(negedge clk); n++; end
    if (!vec_valid) begin
      total++; bad++;
      $display("FAIL R7 no emit act=0 exp=1");
    end
    chk("R7 busy low at emit", 32'(busy), 0);
    va = vec_a; vb = vec_b;
    @(negedge clk);
    chk("R7 emit pulse one cycle", 32'(vec_valid), 0);
  endtask

  task automatic t_reset();
    chk("R1 busy after reset", 32'(busy), 0);
    chk("R1 vec_valid after reset", 32'(vec_valid), 0);
  endtask

  task automatic t_copy_timing();
    logic [31:0] va, vb, v;
    setr(10, 32'h1234_5678); setr(21, 32'hDEAD_0001); setr(20, 0);
    put(0, mk(OMOV, 10, 0, 0));
    put(1, mk(OPN, 0, 0, 21));
    put(2, mk(OPN, 0, 0, 20));
    put(3, mk(OEMIT, 20, 10, 0));
    run(va, vb);
    chk("R3 R11 copy committed at k+2", va, 32'h1234_5678);
    chk("R7 R2 emit operand B", vb, 32'h1234_5678);
    getr(21, v); chk("R3 empty head commits 0", v, 0);
    getr(20, v); chk("R3 host read of committed reg", v, 32'h1234_5678);
  endtask

  task automatic t_fu_lat();
    logic [31:0] va, vb, v;
    setr(10, 100); setr(11, 7); setr(40, 32'hFFFF_FFFF);
    put(0, mk(OMUL, 10, 11, 0));
    put(1, mk(OADD, 10, 11, 0));
    put(2, mk(OITOF, 10, 11, 0));
    put(3, mk(OPN, 0, 0, 0));
    put(4, mk(OPN, 0, 0, 40));
    put(5, mk(OPN, 0, 0, 41));
    put(6, mk(OPN, 0, 0, 42));
    put(7, mk(OPN, 0, 0, 43));
    put(8, mk(OEMIT, 43, 42, 0));
    run(va, vb);
    chk("R4 R11 multiply latency 7", va, 32'd117);
    chk("R4 R11 add latency 5", vb, 32'd115);
    getr(41, v); chk("R4 int-to-float latency 3", v, 32'd120);
    getr(40, v); chk("R3 idle slot commits 0", v, 0);
    put(0, mk(OSIN, 10, 11, 0));
    put(1, mk(OSUB, 10, 11, 0));
    put(2, mk(OPN, 0, 0, 0));
    put(3, mk(OFTOI, 10, 11, 0));
    put(4, mk(OPN, 0, 0, 50));
    put(5, mk(OPN, 0, 0, 51));
    put(6, mk(OPN, 0, 0, 52));
    put(7, mk(OEMIT, 50, 52, 0));
    run(va, vb);
    chk("R4 sine latency 4", va, 32'd122);
    chk("R4 subtract latency 5", vb, 32'd116);
    getr(51, v); chk("R4 float-to-int latency 2", v, 32'd119);
  endtask

  task automatic t_bitops();
    logic [31:0] va, vb, v;
    setr(12, 32'hC049_0FDB); setr(13, 32'h8000_0000); setr(11, 32'h4080_0000);
    setr(14, 32'h1111_1111); setr(15, 32'h2222_2222); setr(2, 5);
    put(0, mk(OABS, 12, 0, 0));
    put(1, mk(ORSQS, 11, 0, 0));
    put(2, mk(OSGNX, 14, 13, 30));
    put(3, mk(OSEL, 14, 15, 31));
    put(4, mk(OPN, 0, 0, 32));
    put(5, mk(OPN, 0, 0, 33));
    put(6, mk(OSGNX, 15, 14, 0));
    put(7, mk(OPN, 0, 0, 0));
    put(8, mk(OPN, 0, 0, 34));
    put(9, mk(OEMIT, 30, 31, 0));
    run(va, vb);
    chk("R9 absolute clears bit 31", va, 32'h4049_0FDB);
    chk("R10 rsqrt seed", vb, 32'h3EF7_59DF);
    getr(32, v); chk("R9 sign transfer with negative B", v, 32'h9111_1111);
    getr(33, v); chk("R8 select with flag set", v, 32'h1111_1111);
    getr(34, v); chk("R9 sign transfer with positive B", v, 32'h2222_2222);
    setr(2, 0);
    put(0, mk(OSEL, 14, 15, 0));
    put(1, mk(OPN, 0, 0, 0));
    put(2, mk(OPN, 0, 0, 35));
    put(3, mk(OEMIT, 35, 0, 0));
    run(va, vb);
    chk("R8 select with flag clear", va, 32'h2222_2222);
  endtask

  task automatic t_collision();
    logic [31:0] va, vb;
    setr(10, 100); setr(11, 7); setr(14, 32'h1111_1111);
    put(0, mk(OMUL, 10, 11, 0));
    for (int i = 1; i < 5; i++) put(i, mk(OPN, 0, 0, 0));
    put(5, mk(OMOV, 14, 0, 0));
    put(6, mk(OPN, 0, 0, 0));
    put(7, mk(OPN, 0, 0, 44));
    put(8, mk(OEMIT, 44, 0, 0));
    run(va, vb);
    chk("R6 later insert wins collision", va, 32'h1111_1111);
  endtask

  task automatic t_dst_zero();
    logic [31:0] va, vb;
    setr(0, 32'hA5A5_A5A5); setr(14, 32'h1111_1111);
    put(0, mk(OMOV, 14, 0, 0));
    put(1, mk(OPN, 0, 0, 0));
    put(2, mk(OPN, 0, 0, 0));
    put(3, mk(OEMIT, 0, 0, 0));
    run(va, vb);
    chk("R5 destination 0 writes nothing", va, 32'hA5A5_A5A5);
  endtask

  task automatic t_emit_restart();
    logic [31:0] va, vb, v;
    setr(45, 32'h5555_0000); setr(46, 32'h0000_0077); setr(14, 32'h1111_1111);
    put(0, mk(OMOV, 14, 0, 0));
    put(1, mk(OPN, 0, 0, 0));
    put(2, mk(OEMIT, 0, 14, 45));
    run(va, vb);
    getr(45, v); chk("R7 emit commits no register", v, 32'h5555_0000);
    put(0, mk(OPN, 0, 0, 46));
    put(1, mk(OEMIT, 46, 0, 0));
    run(va, vb);
    chk("R12 start empties queue and restarts at 0", va, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_copy_timing();
    t_fu_lat();
    t_bitops();
    t_collision();
    t_dst_zero();
    t_emit_restart();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule